// File: doc/BRIEF.md
# Inference Pass Sequencer

This block controls one forward pass of a layered neural-network accelerator. It combines a trigger written by software with a trigger from neighbouring fabric logic, and it starts a pass on the rising edge of the combined signal. It then steps the arithmetic datapath through three hidden layers and one output layer, one after another, using a start/done handshake for each layer. When the last layer completes, it captures the result vector and raises an output-valid flag.

The input vector for the pass comes from one of two sources: register-written inputs or fabric inputs. The choice is made by a select flag, and a configured input count applies to either source. The chosen vector is latched at the moment the pass starts, so the datapath sees stable operands for the whole pass.

The control and status pins are plain levels and pulses. There is no valid/ready stream at the edge because the block never stalls. The datapath's `layer_done` is a one-cycle acknowledge, and the controller always accepts it. Any trigger edge that arrives while a pass is running is dropped rather than queued.

Top module: `infer_seq_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0, `layer_start` is 0 and `result` is all zeros.
- R2: A pass starts only on a 0-to-1 transition of the combined trigger; a trigger held high starts at most one pass.
- R3: The combined trigger is `sw_trig OR (fab_trig AND NOT fab_trig_mask)`, and either source alone can start a pass, with no priority between them.
- R4: While `fab_trig_mask` is 1, edges on `fab_trig` start nothing; `sw_trig` still starts a pass.
- R5: A trigger edge that arrives while `busy` is 1 is ignored: it neither restarts nor queues a pass.
- R6: `out_valid` is 0 from the clock edge that starts a pass until the final layer's done; it rises on the edge that samples the last `layer_done`, and `busy` falls on that same edge.
- R7: A pass issues exactly four one-cycle `layer_start` pulses with `layer_sel` equal to 0, 1, 2, 3 in that order. Each pulse after the first follows the previous `layer_done`. `layer_is_out` is 1 exactly when `layer_sel` is 3.
- R8: `in_vec` element i (bits i*32 +: 32) takes element i of `reg_in_vec` when `use_reg_in` is 1, or element i of `fab_in_vec` when it is 0, for i < `cfg_num_in`. Elements with i >= `cfg_num_in` are 0.
- R9: `in_vec` is captured on the edge that starts a pass and stays stable until the next pass starts, whatever the input sources do.
- R10: `result` takes `dp_result` on the edge that samples the final layer's `layer_done`, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig | input | 1 | Trigger from software register |
| fab_trig | input | 1 | Trigger from fabric logic |
| fab_trig_mask | input | 1 | 1 masks the fabric trigger |
| use_reg_in | input | 1 | 1 selects register inputs, 0 fabric inputs |
| cfg_num_in | input | 5 | Number of active inputs (2..16) |
| reg_in_vec | input | 512 | Register-written input vector, 16 x 32 bit |
| fab_in_vec | input | 512 | Fabric input vector, 16 x 32 bit |
| in_vec | output | 512 | Latched input vector for the datapath |
| layer_start | output | 1 | One-cycle start pulse for the current layer |
| layer_sel | output | 2 | Index of the active layer |
| layer_is_out | output | 1 | Active layer is the linear output layer |
| layer_done | input | 1 | One-cycle done pulse from the datapath |
| dp_result | input | 256 | Datapath output vector, 8 x 32 bit |
| result | output | 256 | Held result vector |
| out_valid | output | 1 | Result is valid, no pass running |
| busy | output | 1 | A pass is in progress |

## Verification
The bench builds the block with its default parameters: 32-bit elements, sixteen inputs, eight outputs and four layers. This makes the full configured-count range, both ends of the input masking, and the complete hidden-then-output layer walk reachable. A behavioural datapath answers each layer start after a fixed latency. This exposes the start/done ordering, the edges ignored mid-pass, and the hold of the inputs and results while the driven sources change.

// File: rtl/infer_seq_pkg.sv
package infer_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/trig_merge_edge.sv
module trig_merge_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_trig,
  input  logic fab_trig,
  input  logic fab_mask,
  output logic rise_o
);
  logic merged;
  logic prev_q;

  assign merged = sw_trig | (fab_trig & ~fab_mask);
  assign rise_o = merged & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= merged;
  end

  // R2
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> prev_q);
endmodule

// File: rtl/input_capture.sv
module input_capture #(
  parameter int DATA_W = 32,
  parameter int MAX_IN = 16,
  parameter int CNT_W  = $clog2(MAX_IN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic                     use_reg_in,
  input  logic [CNT_W-1:0]         cfg_num_in,
  input  logic [MAX_IN*DATA_W-1:0] reg_vec,
  input  logic [MAX_IN*DATA_W-1:0] fab_vec,
  output logic [MAX_IN*DATA_W-1:0] vec_o
);
  logic [MAX_IN*DATA_W-1:0] vec_q;

  for (genvar i = 0; i < MAX_IN; i++) begin : g_elem
    logic [DATA_W-1:0] pick;
    assign pick = use_reg_in ? reg_vec[i*DATA_W +: DATA_W]
                             : fab_vec[i*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (!rst_n)
        vec_q[i*DATA_W +: DATA_W] <= '0;
      else if (capture)
        vec_q[i*DATA_W +: DATA_W] <= (CNT_W'(i) < cfg_num_in) ? pick : '0;
    end
  end

  assign vec_o = vec_q;

  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(vec_o));
endmodule

// File: rtl/layer_sequencer.sv
module layer_sequencer
  import infer_seq_pkg::*;
#(
  parameter int N_LAYERS = 4,
  parameter int IDX_W    = $clog2(N_LAYERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             layer_done,
  output logic             busy,
  output logic             layer_start,
  output logic [IDX_W-1:0] layer_idx,
  output logic             final_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LAYERS - 1);

  seq_st_e          st_q;
  logic             start_q;
  logic [IDX_W-1:0] idx_q;

  assign final_done  = (st_q == ST_RUN) && layer_done && (idx_q == LAST);
  assign busy        = (st_q == ST_RUN);
  assign layer_start = start_q;
  assign layer_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (go) begin
          st_q    <= ST_RUN;
          idx_q   <= '0;
          start_q <= 1'b1;
        end
        ST_RUN: if (layer_done) begin
          if (idx_q == LAST) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  first_layer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (layer_idx == '0 && layer_start));
  // R7
  start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_start |-> busy);
endmodule

// File: rtl/infer_seq_ctrl.sv
module infer_seq_ctrl #(
  parameter int DATA_W   = 32,
  parameter int MAX_IN   = 16,
  parameter int MAX_OUT  = 8,
  parameter int N_LAYERS = 4,
  parameter int CNT_W    = $clog2(MAX_IN + 1),
  parameter int IDX_W    = $clog2(N_LAYERS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sw_trig,
  input  logic                      fab_trig,
  input  logic                      fab_trig_mask,
  input  logic                      use_reg_in,
  input  logic [CNT_W-1:0]          cfg_num_in,
  input  logic [MAX_IN*DATA_W-1:0]  reg_in_vec,
  input  logic [MAX_IN*DATA_W-1:0]  fab_in_vec,
  output logic [MAX_IN*DATA_W-1:0]  in_vec,
  output logic                      layer_start,
  output logic [IDX_W-1:0]          layer_sel,
  output logic                      layer_is_out,
  input  logic                      layer_done,
  input  logic [MAX_OUT*DATA_W-1:0] dp_result,
  output logic [MAX_OUT*DATA_W-1:0] result,
  output logic                      out_valid,
  output logic                      busy
);
  logic rise;
  logic go;
  logic final_done;
  logic [MAX_OUT*DATA_W-1:0] result_q;
  logic valid_q;

  trig_merge_edge u_trig (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .fab_trig(fab_trig),
    .fab_mask(fab_trig_mask), .rise_o(rise)
  );

  assign go = rise & ~busy;

  input_capture #(.DATA_W(DATA_W), .MAX_IN(MAX_IN), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(go), .use_reg_in(use_reg_in),
    .cfg_num_in(cfg_num_in), .reg_vec(reg_in_vec), .fab_vec(fab_in_vec),
    .vec_o(in_vec)
  );

  layer_sequencer #(.N_LAYERS(N_LAYERS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .layer_done(layer_done),
    .busy(busy), .layer_start(layer_start), .layer_idx(layer_sel),
    .final_done(final_done)
  );

  assign layer_is_out = (layer_sel == IDX_W'(N_LAYERS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (final_done) begin
        result_q <= dp_result;
        valid_q  <= 1'b1;
      end else if (go) begin
        valid_q  <= 1'b0;
      end
    end
  end

  assign result    = result_q;
  assign out_valid = valid_q;

  // R6
  valid_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !final_done |=> $stable(result));
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(final_done)) |-> !$rose(layer_start && layer_sel == '0));
endmodule

// File: tb/infer_seq_ctrl_bench.sv
module infer_seq_ctrl_bench;
  localparam int DW = 32, NI = 16, NO = 8, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic sw_trig = 0, fab_trig = 0, fab_trig_mask = 0, use_reg_in = 1;
  logic [4:0] cfg_num_in = 5'd16;
  logic [NI*DW-1:0] reg_in_vec = '0, fab_in_vec = '0, in_vec;
  logic layer_start, layer_is_out, out_valid, busy;
  logic [1:0] layer_sel;
  logic layer_done = 0;
  logic [NO*DW-1:0] dp_result = '0, result;

  int checks = 0, fails = 0;
  int starts = 0, order_err = 0, cyc = 0, dn_cnt = 0;

  always #4 clk = ~clk;

  infer_seq_ctrl u_infer_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .fab_trig(fab_trig),
    .fab_trig_mask(fab_trig_mask), .use_reg_in(use_reg_in),
    .cfg_num_in(cfg_num_in), .reg_in_vec(reg_in_vec), .fab_in_vec(fab_in_vec),
    .in_vec(in_vec), .layer_start(layer_start), .layer_sel(layer_sel),
    .layer_is_out(layer_is_out), .layer_done(layer_done),
    .dp_result(dp_result), .result(result), .out_valid(out_valid), .busy(busy)
  );

  // behavioural datapath: done LAT cycles after each start
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (dn_cnt > 0) begin
      layer_done <= (dn_cnt == 1);
      dn_cnt <= dn_cnt - 1;
    end else layer_done <= 0;
    if (layer_start) begin
      if (layer_sel != 2'(starts % 4) || layer_is_out != (layer_sel == 2'd3)) order_err <= order_err + 1;
      starts <= starts + 1;
      dn_cnt <= LAT;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NI*DW-1:0] pat(input int base);
    logic [NI*DW-1:0] v;
    for (int i = 0; i < NI; i++) v[i*DW +: DW] = DW'(base + i);
    return v;
  endfunction

  function automatic logic [NI*DW-1:0] expect_vec(input bit ureg, input int n,
      input logic [NI*DW-1:0] r, input logic [NI*DW-1:0] f);
    logic [NI*DW-1:0] v = '0;
    for (int i = 0; i < NI; i++) if (i < n) v[i*DW +: DW] = ureg ? r[i*DW +: DW] : f[i*DW +: DW];
    return v;
  endfunction

  task automatic pulse(input bit fab);
    @(negedge clk);
    if (fab) fab_trig = 1; else sw_trig = 1;
    @(negedge clk);
    fab_trig = 0; sw_trig = 0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (out_valid) begin ok = 1; break; end
    end
  endtask

  // {use_reg, num_in[4:0], via_fab, mask, expect_pass}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 5'd16, 1'b0, 1'b0, 1'b1},
    {1'b0, 5'd2,  1'b1, 1'b0, 1'b1},
    {1'b1, 5'd7,  1'b1, 1'b0, 1'b1},
    {1'b0, 5'd13, 1'b0, 1'b1, 1'b1},
    {1'b1, 5'd5,  1'b1, 1'b1, 1'b0},
    {1'b0, 5'd16, 1'b1, 1'b0, 1'b1}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NI*DW-1:0] exp_in;
    logic [NO*DW-1:0] exp_res;
    bit ok;
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !busy && !layer_start && result == '0, "R1", {out_valid, busy, layer_start}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !busy, "R1", {out_valid, busy}, 0);

    for (int t = 0; t < 6; t++) begin
      use_reg_in = VEC[t][8]; cfg_num_in = VEC[t][7:3]; fab_trig_mask = VEC[t][1];
      reg_in_vec = pat(t * 256 + 16); fab_in_vec = pat(t * 256 + 128);
      dp_result = {NO{DW'(32'hA000 + t)}};
      exp_in = expect_vec(VEC[t][8], int'(VEC[t][7:3]), reg_in_vec, fab_in_vec);
      exp_res = dp_result;
      s0 = starts;
      pulse(VEC[t][2]);
      if (VEC[t][0]) begin
        // R6 valid low during pass
        chk(busy && !out_valid, "R6", {busy, out_valid}, 2);
        reg_in_vec = ~reg_in_vec; fab_in_vec = ~fab_in_vec;  // R9 changes ignored
        wait_valid(ok);
        chk(ok, "R3", ok, 1);
        chk(in_vec == exp_in, "R8", in_vec[63:0], exp_in[63:0]);
        chk(result == exp_res, "R10", result[63:0], exp_res[63:0]);
        chk(starts - s0 == 4 && order_err == 0, "R7", starts - s0, 4);
        dp_result = '1;
        repeat (3) @(negedge clk);
        chk(result == exp_res && in_vec == exp_in, "R9", result[63:0], exp_res[63:0]);
      end else begin
        repeat (10) @(negedge clk);
        // R4 masked fabric edge starts nothing
        chk(!busy && starts == s0, "R4", starts - s0, 0);
        chk(out_valid, "R4", out_valid, 1);
      end
    end

    // R4 software trigger still works while mask set
    fab_trig_mask = 1;
    s0 = starts;
    pulse(0);
    wait_valid(ok);
    chk(ok && starts - s0 == 4, "R4", starts - s0, 4);
    fab_trig_mask = 0;

    // R5 edge during pass ignored
    s0 = starts;
    pulse(0);
    repeat (3) @(negedge clk);
    pulse(1);
    wait_valid(ok);
    repeat (10) @(negedge clk);
    chk(ok && !busy && starts - s0 == 4, "R5", starts - s0, 4);

    // R2 held trigger starts one pass only
    s0 = starts;
    @(negedge clk); sw_trig = 1;
    wait_valid(ok);
    repeat (10) @(negedge clk);
    chk(ok && !busy && starts - s0 == 4, "R2", starts - s0, 4);
    // R3 other source rising while combined already high: no edge
    fab_trig = 1;
    repeat (5) @(negedge clk);
    chk(!busy && starts - s0 == 4, "R3", starts - s0, 4);
    sw_trig = 0; fab_trig = 0;

    // R6 valid rises together with busy falling
    pulse(1);
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!busy) begin ok = out_valid; break; end
    end
    chk(ok, "R6", ok, 1);

    // R1 reset mid-pass clears state
    pulse(0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!busy && !out_valid && result == '0, "R1", {busy, out_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule